// File: doc/BRIEF.md
# DAC Load Strobe Advance Generator

This block decides, once in every sample period, the instant at which the next word is loaded into a digital-to-analog converter, and issues a single-cycle load strobe at that instant. The placement is tied to the converter's frame timing. The sample period starts at tick position 0, which is also where the ADC output frame sync occurs. By default the load comes one serial-bit period ahead of that event. A 5-bit advance value can move it earlier still, in steps of one thirty-second of the sample period.

The surrounding clocking logic supplies four things: a prescaled tick enable, the tick's position inside the sample period, a 2-bit code that selects the sample ratio, and the length of one serial bit in ticks. The advance value is written through a plain write-enable and data pair. It is held in a register that accepts writes only while the DAC power-enable input is low, so the load point cannot move under a running converter. The block has no streaming data path. All of its pins are plain control signals, and none of them uses a handshake or back-pressure.

Top module: `dac_load_strobe_gen`

## Requirements
- R1: After reset, `load_stb` is low and the stored advance value is zero.
- R2: With an advance of zero, the strobe follows the tick at position `ratio - bit_ticks`. This is one serial-bit period before the frame-sync position 0.
- R3: Each advance step moves the load point `ratio/32` ticks earlier, so an advance of k selects position `ratio - bit_ticks - k*ratio/32`.
- R4: The load position wraps modulo the sample period when the bit period plus the advance reaches or exceeds the ratio.
- R5: `load_stb` is high for exactly one clock cycle. That cycle is the clock after a cycle in which `tick` is high and `tick_pos` equals the load position. No strobe follows a cycle in which `tick` is low.
- R6: While `dac_pwr_en` is low, no strobe is issued.
- R7: A write to the advance value while `dac_pwr_en` is high is ignored, and the previous value stays in use.
- R8: A write while `dac_pwr_en` is low takes effect from the next clock on.
- R9: `ratio_sel` encodes the sample ratio as 0 for 2048 ticks, 1 for 1024, 2 for 512 and 3 for 256.
- R10: While powered, exactly one strobe is issued per complete sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled tick enable |
| tick_pos | input | POS_W | Tick position inside the sample period (0 = frame sync) |
| ratio_sel | input | 2 | Sample ratio code (R9) |
| bit_ticks | input | BIT_W | Serial-bit period in ticks |
| dac_pwr_en | input | 1 | DAC powered; locks the advance value |
| adv_wr_en | input | 1 | Advance value write strobe |
| adv_wr_data | input | OFS_W | Advance value, 0 to 31 steps |
| load_stb | output | 1 | One-cycle DAC load strobe |

## Verification
The bench builds the block with its default parameters. With POS_W = 11, all four ratios are reachable, up to the 2048-tick period, and the steps can be 8, 16, 32 or 64 ticks. With BIT_W = 4, bit periods of up to 15 ticks are possible. Combined with an advance of 31 at the 256 ratio, this pushes the load position past zero and into the wrap-around case. Sparse tick patterns, and writes made with power on and with power off, exercise the strobe qualification and the lock on the advance value.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    RATIO_X2048 = 2'd0,
    RATIO_X1024 = 2'd1,
    RATIO_X512  = 2'd2,
    RATIO_X256  = 2'd3
  } ratio_sel_t;

  localparam int NUM_RATIOS = 4;
endpackage

// File: rtl/dls_offset_reg.sv
module dls_offset_reg #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_en,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  output logic [OFS_W-1:0] ofs_q
);
  // The stored advance only changes while the converter is unpowered.
  logic accept;
  assign accept = wr_en & ~pwr_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      ofs_q <= '0;
    else if (accept) ofs_q <= wr_data;
  end
endmodule

// File: rtl/dls_pos_calc.sv
module dls_pos_calc
  import dls_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int OFS_W = 5,
  parameter int BIT_W = 4
) (
  input  ratio_sel_t       ratio_sel,
  input  logic [BIT_W-1:0] bit_ticks,
  input  logic [OFS_W-1:0] ofs,
  output logic [POS_W-1:0] load_pos
);
  // Ratio and step for each selector code, built once per option.
  logic [POS_W-1:0] mask_opt [NUM_RATIOS];
  logic [POS_W-1:0] step_opt [NUM_RATIOS];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_opt
    localparam int RATIO_LOG = POS_W - g;
    localparam int STEP_LOG  = RATIO_LOG - OFS_W;
    assign mask_opt[g] = POS_W'((1 << RATIO_LOG) - 1);
    assign step_opt[g] = POS_W'(1 << STEP_LOG);
  end

  logic [POS_W-1:0] mask;
  logic [POS_W-1:0] step;
  logic [POS_W-1:0] adv_ticks;
  logic [POS_W-1:0] raw;

  always_comb begin
    mask      = mask_opt[ratio_sel];
    step      = step_opt[ratio_sel];
    adv_ticks = POS_W'(ofs) * step;
    // Ratio is a power of two: masking the two's-complement difference is the modulo.
    raw       = POS_W'(0) - POS_W'(bit_ticks) - adv_ticks;
    load_pos  = raw & mask;
  end
endmodule

// File: rtl/dls_strobe.sv
module dls_strobe #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwr_en,
  input  logic [POS_W-1:0] tick_pos,
  input  logic [POS_W-1:0] load_pos,
  output logic             stb_q
);
  logic hit;
  assign hit = tick & pwr_en & (tick_pos == load_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= hit;
  end
endmodule

// File: rtl/dac_load_strobe_gen.sv
module dac_load_strobe_gen
  import dls_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int OFS_W = 5,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [POS_W-1:0] tick_pos,
  input  logic [1:0]       ratio_sel,
  input  logic [BIT_W-1:0] bit_ticks,
  input  logic             dac_pwr_en,
  input  logic             adv_wr_en,
  input  logic [OFS_W-1:0] adv_wr_data,
  output logic             load_stb
);
  logic [OFS_W-1:0] ofs_q;
  logic [POS_W-1:0] load_pos;

  dls_offset_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_en  (dac_pwr_en),
    .wr_en   (adv_wr_en),
    .wr_data (adv_wr_data),
    .ofs_q   (ofs_q)
  );

  dls_pos_calc #(.POS_W(POS_W), .OFS_W(OFS_W), .BIT_W(BIT_W)) u_pos (
    .ratio_sel (ratio_sel_t'(ratio_sel)),
    .bit_ticks (bit_ticks),
    .ofs       (ofs_q),
    .load_pos  (load_pos)
  );

  dls_strobe #(.POS_W(POS_W)) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pwr_en   (dac_pwr_en),
    .tick_pos (tick_pos),
    .load_pos (load_pos),
    .stb_q    (load_stb)
  );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int OFS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             dac_pwr_en,
  input logic             adv_wr_en,
  input logic [OFS_W-1:0] adv_wr_data,
  input logic [OFS_W-1:0] ofs_q,
  input logic             load_stb
);
  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(tick)); // R5
  AST_NO_STB_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(dac_pwr_en)); // R6
  AST_OFS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dac_pwr_en) |-> $stable(ofs_q)); // R7
  AST_OFS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_wr_en && !dac_pwr_en) |=> (ofs_q == $past(adv_wr_data))); // R8
endmodule

bind dac_load_strobe_gen dls_checker #(.OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .dac_pwr_en  (dac_pwr_en),
  .adv_wr_en   (adv_wr_en),
  .adv_wr_data (adv_wr_data),
  .ofs_q       (ofs_q),
  .load_stb    (load_stb)
);

// File: tb/dac_load_strobe_gen_bench.sv
module dac_load_strobe_gen_bench;
  localparam int POS_W = 11;
  localparam int OFS_W = 5;
  localparam int BIT_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [POS_W-1:0] tick_pos = '0;
  logic [1:0]       ratio_sel = 2'd3;
  logic [BIT_W-1:0] bit_ticks = 4'd4;
  logic             dac_pwr_en = 1'b0;
  logic             adv_wr_en = 1'b0;
  logic [OFS_W-1:0] adv_wr_data = '0;
  logic             load_stb;

  dac_load_strobe_gen u_dac_load_strobe_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_pos(tick_pos),
    .ratio_sel(ratio_sel), .bit_ticks(bit_ticks), .dac_pwr_en(dac_pwr_en),
    .adv_wr_en(adv_wr_en), .adv_wr_data(adv_wr_data), .load_stb(load_stb)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  int    m_off = 0;
  bit    exp_stb = 1'b0;
  bit    counting = 1'b0;
  int    stb_cnt = 0;
  bit    done = 1'b0;

  function automatic int ratio_of(int sel);
    return 2048 >> sel;   // R9 encoding
  endfunction

  function automatic int model_pos(int sel, int b, int o);
    int r = ratio_of(sel);
    int v = (-b - o * (r / 32)) % r;
    if (v < 0) v += r;
    return v;
  endfunction

  // Reference model: decides the strobe for the next clock from current inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_stb = 1'b0;
      m_off   = 0;
    end else begin
      exp_stb = tick && dac_pwr_en &&
                (int'(tick_pos) == model_pos(int'(ratio_sel), int'(bit_ticks), m_off));
      if (adv_wr_en && !dac_pwr_en) m_off = int'(adv_wr_data);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (load_stb !== exp_stb) begin
        n_bad++;
        $display("FAIL %s: load_stb=%0b expected=%0b tick_pos=%0d", phase, load_stb, exp_stb, tick_pos);
      end
      if (counting && load_stb === 1'b1) stb_cnt++;
    end
  end

  task automatic report();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic run_ticks(int n, int gap);
    int p = 0;
    int r = ratio_of(int'(ratio_sel));
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      tick_pos = POS_W'(p);
      @(negedge clk);
      tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      p = (p + 1) % r;
    end
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic count_periods(int periods, int gap, int expect_n);
    counting = 1'b1;
    stb_cnt = 0;
    run_ticks(periods * ratio_of(int'(ratio_sel)), gap);
    counting = 1'b0;
    n_cmp++;
    if (stb_cnt != expect_n) begin
      n_bad++;
      $display("FAIL %s: strobe count=%0d expected=%0d", phase, stb_cnt, expect_n);
    end
  endtask

  task automatic write_adv(int v);
    adv_wr_en = 1'b1;
    adv_wr_data = OFS_W'(v);
    @(negedge clk);
    adv_wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (load_stb !== 1'b0) begin  // R1
      n_bad++;
      $display("FAIL R1: load_stb=%0b expected=0 in reset", load_stb);
    end
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R6";                       // unpowered: nothing issued
    count_periods(2, 0, 0);

    phase = "R2";                       // reset advance zero (R1), ratio 256
    dac_pwr_en = 1'b1;
    count_periods(2, 0, 2);

    phase = "R9";                       // 2048-tick ratio, bit period 1
    ratio_sel = 2'd0; bit_ticks = 4'd1;
    count_periods(1, 0, 1);

    phase = "R8";                       // write accepted while unpowered
    dac_pwr_en = 1'b0;
    write_adv(5);
    dac_pwr_en = 1'b1;
    phase = "R3";                       // 512 ratio, step 16
    ratio_sel = 2'd2; bit_ticks = 4'd8;
    count_periods(2, 0, 2);

    phase = "R4";                       // 256 - 12 - 31*8 wraps to 252
    dac_pwr_en = 1'b0;
    write_adv(31);
    dac_pwr_en = 1'b1;
    ratio_sel = 2'd3; bit_ticks = 4'd12;
    count_periods(2, 0, 2);

    phase = "R7";                       // write ignored while powered
    write_adv(3);
    ratio_sel = 2'd1; bit_ticks = 4'd2;
    count_periods(1, 0, 1);

    phase = "R5";                       // sparse ticks
    ratio_sel = 2'd3;
    count_periods(2, 2, 2);

    phase = "R10";
    dac_pwr_en = 1'b0;
    write_adv(0);
    dac_pwr_en = 1'b1;
    bit_ticks = 4'd15;
    count_periods(3, 0, 3);

    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
  end
endmodule